// File: doc/BRIEF.md
# Communication Watchdog Fail-Safe Controller

This block sits beside a serial command decoder and watches for valid frames. Each valid frame restarts a watchdog counter. If no frame arrives before the programmed limit runs out, the block raises a fail-safe flag. While that flag is set, every driven output switches from its normal value to one of two fail-safe patterns. A per-output map bit chooses which pattern each output follows.

A 4-bit timeout code sets the watchdog behaviour. It can turn the watchdog off, select one of eleven limits, or force fail-safe at once. A second, independent timer measures bus idle time after the last bus activity. When the time set by a 3-bit break code has passed, it emits a one-cycle break pulse that the protocol layer uses to frame transactions. An acknowledgement-enable bit is held and exposed for the protocol layer.

All configuration fields load from a non-volatile image while reset is held, so they hold that image when reset is released. A configuration write strobe can replace them later. Time is measured in ticks of a 1 µs enable input. The parameter `TIME_SHIFT` divides every limit by 2^`TIME_SHIFT`, so a block that ticks faster can be scaled. All pins are plain control and status signals. No pin carries a data stream, so there is no back-pressure.

Top module: `commwd_failsafe`

## Requirements
- R1: With timeout code 0 the watchdog is off: if the fail-safe flag is clear, it stays clear however long no frame arrives.
- R2: Codes 1 to 11 select the limit in µs: 1=200, 2=500, 3=1000, 4=2000, 5=5000, 6=10000, 7=20000, 8=50000, 9=100000, 10=200000, 11=500000. The limit in ticks is L = µs >> TIME_SHIFT. After a frame, the flag sets on the clock edge that follows the L-th tick.
- R3: Codes 12 to 15 force fail-safe. The flag is set on the clock after such a code is in the register, and frames do not clear it.
- R4: Under a non-forcing code, a valid frame reloads the counter and clears the fail-safe flag on the next clock.
- R5: When the timeout code register changes, the counter reloads with the new code's limit on the following clock. It then counts down from that value.
- R6: In fail-safe, output i takes bit i of pattern 0 when map bit i is 0, and bit i of pattern 1 when map bit i is 1.
- R7: Outside fail-safe, the drive outputs equal the normal drive inputs.
- R8: The break code selects an idle time in µs: 0=1000, 1=125, 2=250, 3=500, 4=1250, 5=2500, 6=5000, 7=5000. The idle time in ticks is B = µs >> TIME_SHIFT. After bus activity, `brk_pulse` is high for exactly one cycle, on the edge after the B-th tick.
- R9: Bus activity before the break pulse fires restarts the idle count from the full value, and suppresses the pulse on the next cycle.
- R10: While reset is held, all configuration fields take the non-volatile image. A write strobe replaces all fields on the next clock.
- R11: `ack_en` shows the stored acknowledgement-enable bit (1 = enabled).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high; loads the non-volatile image |
| tick_1us | input | 1 | Time-base enable, one cycle per µs |
| frame_ok | input | 1 | One-cycle strobe per valid frame |
| bus_act | input | 1 | One-cycle strobe per bus activity |
| nv_wd_code | input | 4 | Image: timeout code |
| nv_brk_code | input | 3 | Image: break code |
| nv_ack_en | input | 1 | Image: acknowledgement enable |
| nv_out_map | input | N_OUT | Image: per-output pattern select |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wd_code | input | 4 | Written timeout code |
| cfg_brk_code | input | 3 | Written break code |
| cfg_ack_en | input | 1 | Written acknowledgement enable |
| cfg_out_map | input | N_OUT | Written per-output pattern select |
| drv_in | input | N_OUT | Normal drive values |
| fs_pat0 | input | N_OUT | Fail-safe pattern 0 |
| fs_pat1 | input | N_OUT | Fail-safe pattern 1 |
| fail_safe | output | 1 | Fail-safe flag |
| drv_out | output | N_OUT | Resolved drive values |
| brk_pulse | output | 1 | One-cycle transaction-break pulse |
| ack_en | output | 1 | Acknowledgement enable for the protocol layer |

## Verification
The bench builds the block with `N_OUT` = 16 and `TIME_SHIFT` = 4. This brings the longest limit, 500 ms, down to 31250 ticks, so every timeout and every break code can run within the cycle budget. The time-base enable runs on every cycle in most phases and on every third cycle in one phase. This shows that the counters advance only on ticks. Exact-edge checks pin the fail-safe and break timings to the cycle. A code change during a countdown shows that the counter reloads.

// File: rtl/commwd_pkg.sv
package commwd_pkg;
  localparam int unsigned WD_CODE_W  = 4;
  localparam int unsigned BRK_CODE_W = 3;
  localparam int unsigned MAX_US     = 500000;
  localparam int unsigned CNT_W      = $clog2(MAX_US + 1);

  typedef logic [CNT_W-1:0] ticks_t;

  // Watchdog limit in ticks for a timeout code; 0 for off/forced codes.
  function automatic ticks_t wd_ticks(input logic [WD_CODE_W-1:0] code,
                                      input int unsigned shift);
    int unsigned us;
    case (code)
      4'h1: us = 200;
      4'h2: us = 500;
      4'h3: us = 1000;
      4'h4: us = 2000;
      4'h5: us = 5000;
      4'h6: us = 10000;
      4'h7: us = 20000;
      4'h8: us = 50000;
      4'h9: us = 100000;
      4'hA: us = 200000;
      4'hB: us = 500000;
      default: us = 0;
    endcase
    return ticks_t'(us >> shift);
  endfunction

  // Idle time in ticks for a break code.
  function automatic ticks_t brk_ticks(input logic [BRK_CODE_W-1:0] code,
                                       input int unsigned shift);
    int unsigned us;
    case (code)
      3'd0: us = 1000;
      3'd1: us = 125;
      3'd2: us = 250;
      3'd3: us = 500;
      3'd4: us = 1250;
      3'd5: us = 2500;
      default: us = 5000;
    endcase
    return ticks_t'(us >> shift);
  endfunction

  // Codes with both top bits set demand immediate fail-safe.
  function automatic logic wd_forced(input logic [WD_CODE_W-1:0] code);
    return code[3] & code[2];
  endfunction
endpackage

// File: rtl/commwd_cfg.sv
module commwd_cfg
  import commwd_pkg::*;
#(
  parameter int unsigned N_OUT = 16
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [WD_CODE_W-1:0]  nv_wd_code,
  input  logic [BRK_CODE_W-1:0] nv_brk_code,
  input  logic                  nv_ack_en,
  input  logic [N_OUT-1:0]      nv_out_map,
  input  logic                  cfg_wr,
  input  logic [WD_CODE_W-1:0]  cfg_wd_code,
  input  logic [BRK_CODE_W-1:0] cfg_brk_code,
  input  logic                  cfg_ack_en,
  input  logic [N_OUT-1:0]      cfg_out_map,
  output logic [WD_CODE_W-1:0]  wd_code,
  output logic [BRK_CODE_W-1:0] brk_code,
  output logic                  ack_en,
  output logic [N_OUT-1:0]      out_map
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wd_code  <= nv_wd_code;
      brk_code <= nv_brk_code;
      ack_en   <= nv_ack_en;
      out_map  <= nv_out_map;
    end else if (cfg_wr) begin
      wd_code  <= cfg_wd_code;
      brk_code <= cfg_brk_code;
      ack_en   <= cfg_ack_en;
      out_map  <= cfg_out_map;
    end
  end
endmodule

// File: rtl/commwd_timer.sv
module commwd_timer
  import commwd_pkg::*;
#(
  parameter int unsigned TIME_SHIFT = 0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 frame_ok,
  input  logic [WD_CODE_W-1:0] code,
  output logic                 fail_safe
);
  ticks_t                 cnt;
  ticks_t                 lim;
  logic [WD_CODE_W-1:0]   code_q;
  logic                   forced;

  always_comb begin
    lim    = wd_ticks(code, TIME_SHIFT);
    forced = wd_forced(code);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      code_q    <= '0;
      fail_safe <= 1'b0;
    end else begin
      code_q <= code;
      if (forced) begin
        fail_safe <= 1'b1;
      end else if (frame_ok) begin
        cnt       <= lim;
        fail_safe <= 1'b0;
      end else if (code != code_q || code == '0) begin
        cnt <= lim;
      end else if (cnt == '0) begin
        fail_safe <= 1'b1;
      end else if (tick) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/commwd_break.sv
module commwd_break
  import commwd_pkg::*;
#(
  parameter int unsigned TIME_SHIFT = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick,
  input  logic                  bus_act,
  input  logic [BRK_CODE_W-1:0] code,
  output logic                  brk_pulse
);
  ticks_t cnt;
  logic   armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      armed     <= 1'b0;
      brk_pulse <= 1'b0;
    end else begin
      brk_pulse <= 1'b0;
      if (bus_act) begin
        cnt   <= brk_ticks(code, TIME_SHIFT);
        armed <= 1'b1;
      end else if (armed) begin
        if (cnt == '0) begin
          brk_pulse <= 1'b1;
          armed     <= 1'b0;
        end else if (tick) begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/commwd_outsel.sv
module commwd_outsel #(
  parameter int unsigned N_OUT = 16
) (
  input  logic             fail_safe,
  input  logic [N_OUT-1:0] out_map,
  input  logic [N_OUT-1:0] drv_in,
  input  logic [N_OUT-1:0] fs_pat0,
  input  logic [N_OUT-1:0] fs_pat1,
  output logic [N_OUT-1:0] drv_out
);
  for (genvar i = 0; i < N_OUT; i++) begin : g_bit
    logic fs_bit;
    assign fs_bit     = out_map[i] ? fs_pat1[i] : fs_pat0[i];
    assign drv_out[i] = fail_safe ? fs_bit : drv_in[i];
  end
endmodule

// File: rtl/commwd_failsafe.sv
module commwd_failsafe
  import commwd_pkg::*;
#(
  parameter int unsigned N_OUT      = 16,
  parameter int unsigned TIME_SHIFT = 0
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tick_1us,
  input  logic                  frame_ok,
  input  logic                  bus_act,
  input  logic [WD_CODE_W-1:0]  nv_wd_code,
  input  logic [BRK_CODE_W-1:0] nv_brk_code,
  input  logic                  nv_ack_en,
  input  logic [N_OUT-1:0]      nv_out_map,
  input  logic                  cfg_wr,
  input  logic [WD_CODE_W-1:0]  cfg_wd_code,
  input  logic [BRK_CODE_W-1:0] cfg_brk_code,
  input  logic                  cfg_ack_en,
  input  logic [N_OUT-1:0]      cfg_out_map,
  input  logic [N_OUT-1:0]      drv_in,
  input  logic [N_OUT-1:0]      fs_pat0,
  input  logic [N_OUT-1:0]      fs_pat1,
  output logic                  fail_safe,
  output logic [N_OUT-1:0]      drv_out,
  output logic                  brk_pulse,
  output logic                  ack_en
);
  logic [WD_CODE_W-1:0]  wd_code_q;
  logic [BRK_CODE_W-1:0] brk_code_q;
  logic [N_OUT-1:0]      out_map_q;

  commwd_cfg #(.N_OUT(N_OUT)) u_cfg (
    .clk(clk), .rst(rst),
    .nv_wd_code(nv_wd_code), .nv_brk_code(nv_brk_code),
    .nv_ack_en(nv_ack_en), .nv_out_map(nv_out_map),
    .cfg_wr(cfg_wr), .cfg_wd_code(cfg_wd_code), .cfg_brk_code(cfg_brk_code),
    .cfg_ack_en(cfg_ack_en), .cfg_out_map(cfg_out_map),
    .wd_code(wd_code_q), .brk_code(brk_code_q),
    .ack_en(ack_en), .out_map(out_map_q)
  );

  commwd_timer #(.TIME_SHIFT(TIME_SHIFT)) u_timer (
    .clk(clk), .rst(rst), .tick(tick_1us), .frame_ok(frame_ok),
    .code(wd_code_q), .fail_safe(fail_safe)
  );

  commwd_break #(.TIME_SHIFT(TIME_SHIFT)) u_break (
    .clk(clk), .rst(rst), .tick(tick_1us), .bus_act(bus_act),
    .code(brk_code_q), .brk_pulse(brk_pulse)
  );

  commwd_outsel #(.N_OUT(N_OUT)) u_outsel (
    .fail_safe(fail_safe), .out_map(out_map_q), .drv_in(drv_in),
    .fs_pat0(fs_pat0), .fs_pat1(fs_pat1), .drv_out(drv_out)
  );
endmodule

// File: rtl/commwd_failsafe_chk.sv
module commwd_failsafe_chk (
  input logic       clk,
  input logic       rst,
  input logic       frame_ok,
  input logic       bus_act,
  input logic [3:0] wd_code,
  input logic       fail_safe,
  input logic       brk_pulse
);
  assert_disabled_holds_R1: assert property (@(posedge clk) disable iff (rst)
    (!fail_safe && wd_code == 4'h0) |=> !fail_safe);

  assert_forced_entry_R3: assert property (@(posedge clk) disable iff (rst)
    (wd_code >= 4'hC) |=> fail_safe);

  assert_frame_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (frame_ok && wd_code < 4'hC) |=> !fail_safe);

  assert_pulse_single_R8: assert property (@(posedge clk) disable iff (rst)
    brk_pulse |=> !brk_pulse);

  assert_activity_restarts_R9: assert property (@(posedge clk) disable iff (rst)
    bus_act |=> !brk_pulse);
endmodule

bind commwd_failsafe commwd_failsafe_chk u_chk (
  .clk(clk), .rst(rst), .frame_ok(frame_ok), .bus_act(bus_act),
  .wd_code(wd_code_q), .fail_safe(fail_safe), .brk_pulse(brk_pulse)
);

// File: tb/sim_commwd_failsafe.sv
`timescale 1ns/1ps
module sim_commwd_failsafe;
  localparam int N  = 16;
  localparam int SH = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick_1us = 1'b0, frame_ok = 1'b0, bus_act = 1'b0, cfg_wr = 1'b0;
  logic [3:0] nv_wd_code = 4'h1, cfg_wd_code = 4'h0;
  logic [2:0] nv_brk_code = 3'd1, cfg_brk_code = 3'd0;
  logic nv_ack_en = 1'b1, cfg_ack_en = 1'b0;
  logic [N-1:0] nv_out_map = 16'hA5C3, cfg_out_map = '0;
  logic [N-1:0] drv_in = '0, fs_pat0 = 16'h0F0F, fs_pat1 = 16'h3355;
  logic fail_safe, brk_pulse, ack_en;
  logic [N-1:0] drv_out;

  int checks = 0, errors = 0, cyc = 0, tick_every = 1, tick_ctr = 0;
  string cur_req = "R2";
  bit started = 0;

  commwd_failsafe #(.N_OUT(N), .TIME_SHIFT(SH)) u0 (
    .clk(clk), .rst(rst), .tick_1us(tick_1us), .frame_ok(frame_ok), .bus_act(bus_act),
    .nv_wd_code(nv_wd_code), .nv_brk_code(nv_brk_code), .nv_ack_en(nv_ack_en),
    .nv_out_map(nv_out_map), .cfg_wr(cfg_wr), .cfg_wd_code(cfg_wd_code),
    .cfg_brk_code(cfg_brk_code), .cfg_ack_en(cfg_ack_en), .cfg_out_map(cfg_out_map),
    .drv_in(drv_in), .fs_pat0(fs_pat0), .fs_pat1(fs_pat1),
    .fail_safe(fail_safe), .drv_out(drv_out), .brk_pulse(brk_pulse), .ack_en(ack_en)
  );

  always #2 clk = ~clk;

  // Reference tables straight from the requirements
  function automatic int wd_us(input logic [3:0] c);
    int t [12] = '{0, 200, 500, 1000, 2000, 5000, 10000, 20000, 50000, 100000, 200000, 500000};
    return (c < 12) ? t[c] : 0;
  endfunction
  function automatic int brk_us(input logic [2:0] c);
    int t [8] = '{1000, 125, 250, 500, 1250, 2500, 5000, 5000};
    return t[c];
  endfunction

  // Behavioural reference model
  logic [3:0] m_wd, m_cq;
  logic [2:0] m_brk;
  logic m_ack, m_fs, m_armed, m_pulse;
  logic [N-1:0] m_map;
  int m_cnt, m_bcnt;

  always @(posedge clk) begin
    if (rst) begin
      m_wd = nv_wd_code; m_brk = nv_brk_code; m_ack = nv_ack_en; m_map = nv_out_map;
      m_fs = 0; m_cnt = 0; m_cq = 0; m_armed = 0; m_bcnt = 0; m_pulse = 0;
    end else begin
      if (m_wd >= 12) m_fs = 1;
      else if (frame_ok) begin m_cnt = wd_us(m_wd) >> SH; m_fs = 0; end
      else if (m_wd != m_cq || m_wd == 0) m_cnt = wd_us(m_wd) >> SH;
      else if (m_cnt == 0) m_fs = 1;
      else if (tick_1us) m_cnt--;
      m_cq = m_wd;
      m_pulse = 0;
      if (bus_act) begin m_bcnt = brk_us(m_brk) >> SH; m_armed = 1; end
      else if (m_armed) begin
        if (m_bcnt == 0) begin m_pulse = 1; m_armed = 0; end
        else if (tick_1us) m_bcnt--;
      end
      if (cfg_wr) begin
        m_wd = cfg_wd_code; m_brk = cfg_brk_code; m_ack = cfg_ack_en; m_map = cfg_out_map;
      end
    end
    started = 1;
  end

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    if (started && !rst) begin
      logic [N-1:0] exp_drv;
      exp_drv = m_fs ? ((fs_pat0 & ~m_map) | (fs_pat1 & m_map)) : drv_in;
      check(cur_req, "fail_safe", fail_safe, m_fs);
      check(m_fs ? "R6" : "R7", "drv_out", drv_out, exp_drv);
      check("R8", "brk_pulse", brk_pulse, m_pulse);
      check("R11", "ack_en", ack_en, m_ack);
    end
  end

  // Time base and free-running drive data
  always @(negedge clk) begin
    #1;
    tick_ctr++;
    tick_1us = (tick_ctr % tick_every) == 0;
    drv_in = N'($urandom);
    cyc++;
    if (cyc > 190000) begin
      errors++; checks++;
      $display("FAIL R2 watchdog expired: actual=%0d expected<190000", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic pulse_frame();
    @(negedge clk); #1 frame_ok = 1; @(negedge clk); #1 frame_ok = 0;
  endtask
  task automatic pulse_act();
    @(negedge clk); #1 bus_act = 1; @(negedge clk); #1 bus_act = 0;
  endtask
  task automatic cfg_write(input logic [3:0] w, input logic [2:0] b, input logic a, input logic [N-1:0] m);
    @(negedge clk); #1;
    cfg_wd_code = w; cfg_brk_code = b; cfg_ack_en = a; cfg_out_map = m; cfg_wr = 1;
    @(negedge clk); #1 cfg_wr = 0;
  endtask
  task automatic do_reset(input logic [3:0] w, input logic [2:0] b, input logic a, input logic [N-1:0] m);
    @(negedge clk); #1;
    rst = 1; nv_wd_code = w; nv_brk_code = b; nv_ack_en = a; nv_out_map = m;
    idle(3); #1 rst = 0;
  endtask

  initial begin
    // R10: image loaded during reset
    do_reset(4'h1, 3'd1, 1'b1, 16'hA5C3);
    @(negedge clk);
    check("R10", "fail_safe after reset", fail_safe, 0);
    check("R11", "ack_en from image", ack_en, 1);
    check("R7", "pass-through", drv_out, drv_in);
    // R2: code 1 -> 200>>4 = 12 ticks
    cur_req = "R2";
    pulse_frame();
    idle(12); check("R2", "fs before limit", fail_safe, 0);
    idle(1);  check("R2", "fs at limit", fail_safe, 1);
    check("R6", "mapped patterns", drv_out, (16'h0F0F & ~16'hA5C3) | (16'h3355 & 16'hA5C3));
    // R4: frame clears, regular frames keep it clear
    cur_req = "R4";
    pulse_frame(); check("R4", "fs cleared by frame", fail_safe, 0);
    for (int i = 0; i < 8; i++) begin pulse_frame(); idle(6); end
    check("R4", "fs with steady frames", fail_safe, 0);
    // R1: disabled
    cur_req = "R1";
    cfg_write(4'h0, 3'd1, 1'b0, 16'h00FF);
    check("R11", "ack_en after write", ack_en, 0);
    idle(2000); check("R1", "fs with watchdog off", fail_safe, 0);
    // R3: forced codes ignore frames
    cur_req = "R3";
    cfg_write(4'hD, 3'd1, 1'b0, 16'h00FF);
    idle(1); check("R3", "forced entry", fail_safe, 1);
    pulse_frame(); idle(1); check("R3", "frame ignored when forced", fail_safe, 1);
    fs_pat0 = 16'hFFFF; fs_pat1 = 16'h0000;
    idle(1); check("R6", "map select 00FF", drv_out, 16'hFF00);
    cfg_write(4'hF, 3'd1, 1'b0, 16'h00FF);
    idle(2); check("R3", "code F forced", fail_safe, 1);
    // R5: code change reloads the counter
    cur_req = "R5";
    cfg_write(4'h4, 3'd1, 1'b1, 16'h1234);
    pulse_frame(); idle(20);
    cfg_write(4'h1, 3'd1, 1'b1, 16'h1234);
    idle(13); check("R5", "fs before new limit", fail_safe, 0);
    idle(1);  check("R5", "fs at new limit", fail_safe, 1);
    // Sparse ticks: counter only moves on ticks
    cur_req = "R2";
    tick_every = 3;
    pulse_frame(); idle(30); check("R2", "fs with slow ticks", fail_safe, 0);
    idle(20); check("R2", "fs after slow ticks", fail_safe, 1);
    tick_every = 1;
    // R8/R9: break timer, code 1 -> 125>>4 = 7 ticks
    pulse_act();
    idle(7); check("R8", "no pulse before idle", brk_pulse, 0);
    idle(1); check("R8", "pulse at idle", brk_pulse, 1);
    idle(1); check("R8", "pulse one cycle", brk_pulse, 0);
    pulse_act(); idle(5); pulse_act();
    idle(7); check("R9", "restart delays pulse", brk_pulse, 0);
    idle(1); check("R9", "pulse after restart", brk_pulse, 1);
    cfg_write(4'h1, 3'd6, 1'b1, 16'h1234);
    pulse_act(); idle(400);
    for (int b = 0; b < 8; b++) begin
      cfg_write(4'h0, 3'(b), 1'b1, 16'h1234);
      pulse_act(); idle(320);
    end
    // Longest watchdog limit: 500000>>4 = 31250 ticks
    cur_req = "R2";
    cfg_write(4'hB, 3'd1, 1'b1, 16'hFFFF);
    pulse_frame();
    idle(31250); check("R2", "fs before 500ms", fail_safe, 0);
    idle(1);     check("R2", "fs at 500ms", fail_safe, 1);
    // Second reset with a different image
    cur_req = "R10";
    do_reset(4'hC, 3'd2, 1'b0, 16'h0000);
    @(negedge clk);
    check("R10", "ack_en new image", ack_en, 0);
    idle(1); check("R10", "forced code from image", fail_safe, 1);
    idle(5);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule